// File: doc/BRIEF.md
# Compressor-Tree Multiply-Accumulate Unit

This unit multiplies two unsigned 16-bit operands and adds the product to a 32-bit running total in the same clock cycle. It is meant to sit in the inner loop of a FIR filter. Each enabled clock folds one sample-times-coefficient term into the total. Q8 fixed-point samples and coefficients can be fed in as raw unsigned words, and software rescales the total afterwards.

The datapath has four parts:
- An AND array forms sixteen shifted partial-product rows.
- Three stages of row compressors cut those sixteen rows down to two. The first stage uses 5:2 cells, the second mixes 4:2 and 3:2 cells, and the last is a 4:2 stage.
- A 3:2 row merges the two product rows with the current total.
- A carry-select adder resolves the last two rows. Each block of that adder computes its sum for a block carry-in of 0 and of 1 from shared propagate and generate terms, and a multiplexer then picks one of the two.

The register update is chosen by a three-way selector with these values:
- `ACC_ZERO`, taken when clear is high.
- `ACC_ADD`, taken when clear is low and enable is high.
- `ACC_HOLD`, taken otherwise.

The selector is evaluated fresh each cycle, so every value can follow every other value. The register only ever moves to one of three places: zero, the total plus the product, or its current value.

Top module: `mac_top`

## Requirements
- R1: While `rst_n` is low, `acc_out` is 0. The reset is asynchronous and active low.
- R2: On a rising edge with `clr` low and `en` high, `acc_out` becomes its previous value plus `op_a*op_b`, both operands taken as unsigned.
- R3: The sum wraps modulo 2^32. Carries out of bit 31 are discarded.
- R4: On a rising edge with `clr` high, `acc_out` becomes 0 whatever `en` is. Clear takes priority over enable.
- R5: On a rising edge with `clr` and `en` both low, `acc_out` keeps its value, and the operands have no effect on it.
- R6: The product is exact over the full operand range. For example, 0xFFFF*0xFFFF adds 0xFFFE0001.
- R7: The two rows out of the compressor tree sum, modulo 2^32, to `op_a*op_b` in every cycle.
- R8: A sequence of 21 enabled terms after a clear leaves `acc_out` equal to the 32-bit sum of the 21 products.
- R9: The new total is visible on `acc_out` right after the edge that takes it in. There is no added pipeline latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the running total |
| en | input | 1 | Adds the current product when high |
| op_a | input | 16 | Unsigned multiplicand (sample) |
| op_b | input | 16 | Unsigned multiplier (coefficient) |
| acc_out | output | 32 | Running total register |

## Verification
Several properties are checked on every clock:
- The compressor tree's two rows always sum to the true product.
- Each enabled edge adds exactly that product to the total.
- A clear always lands on zero.
- An idle edge leaves the total untouched.
- All-ones operands always add the largest product.

The reset value, the wrap past 2^32, the 21-term filter sum and the long mixed runs of clear, enable and idle cycles can only be shown by the bench's scenarios. There, a behavioural model is compared with the output after every edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Full-adder cell result: sum at the column weight, carry one column up.
    typedef struct packed {
        logic s;
        logic c;
    } fa_t;

    // Update selected for the running-total register.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ZERO = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

    function automatic fa_t fa3(input logic x, input logic y, input logic z);
        fa_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/mac_row52.sv
// Row of 5:2 compressors. At each column there are five data bits plus two
// carry-ins from the column below. The outputs are a sum bit, a carry bit one
// column up, and two carry-outs that enter the next column as its carry-ins.
module mac_row52 #(
    parameter int W = 32
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    input  logic [W-1:0] x4,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    import mac_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_t f1;
        fa_t f2;
        fa_t f3;
        logic ci1;
        logic ci2;

        if (i == 0) begin : g_first
            assign ci1  = 1'b0;
            assign ci2  = 1'b0;
            assign c[0] = 1'b0;
        end else begin : g_chain
            assign ci1  = g_bit[i-1].f1.c;
            assign ci2  = g_bit[i-1].f2.c;
            assign c[i] = g_bit[i-1].f3.c;
        end

        assign f1   = fa3(x0[i], x1[i], x2[i]);
        assign f2   = fa3(f1.s, x3[i], x4[i]);
        assign f3   = fa3(f2.s, ci1, ci2);
        assign s[i] = f3.s;

        if (i == W-1) begin : g_top
            // carries beyond the word are dropped (modulo 2^W)
            logic [2:0] tail_unused;
            assign tail_unused = {f1.c, f2.c, f3.c};
        end
    end

endmodule

// File: rtl/mac_row42.sv
// Row of 4:2 compressors. At each column there are four data bits plus one
// carry-in from the column below. The outputs are a sum bit, a carry bit one
// column up, and a carry-out that feeds the next column's carry-in.
module mac_row42 #(
    parameter int W = 32
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    import mac_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fa_t  f1;
        fa_t  f2;
        logic cin;

        if (i == 0) begin : g_first
            assign cin  = 1'b0;
            assign c[0] = 1'b0;
        end else begin : g_chain
            assign cin  = g_bit[i-1].f1.c;
            assign c[i] = g_bit[i-1].f2.c;
        end

        assign f1   = fa3(x0[i], x1[i], x2[i]);
        assign f2   = fa3(f1.s, x3[i], cin);
        assign s[i] = f2.s;

        if (i == W-1) begin : g_top
            logic [1:0] tail_unused;
            assign tail_unused = {f1.c, f2.c};
        end
    end

endmodule

// File: rtl/mac_comp_tree.sv
// AND-array partial products reduced to two rows.
// Stage 1: three 5:2 rows (15 rows -> 6), with row 15 passing through.
// Stage 2: one 4:2 row and one 3:2 row (7 -> 4).
// Stage 3: one 4:2 row (4 -> 2).
// The stage layout is drawn for OP_W = 16.
module mac_comp_tree #(
    parameter int OP_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    output logic [OUT_W-1:0] row_s,
    output logic [OUT_W-1:0] row_c
);
    import mac_pkg::*;

    localparam int N52 = 3;

    logic [OUT_W-1:0] pp [OP_W];
    logic [OUT_W-1:0] s1 [N52];
    logic [OUT_W-1:0] c1 [N52];
    logic [OUT_W-1:0] s2a, c2a, s2b, c2b;

    // partial-product AND array
    for (genvar r = 0; r < OP_W; r++) begin : g_pp
        assign pp[r] = ({OUT_W{b[r]}} & OUT_W'(a)) << r;
    end

    // stage 1
    for (genvar g = 0; g < N52; g++) begin : g_s1
        mac_row52 #(.W(OUT_W)) u_row52 (
            .x0(pp[5*g]),   .x1(pp[5*g+1]), .x2(pp[5*g+2]),
            .x3(pp[5*g+3]), .x4(pp[5*g+4]),
            .s(s1[g]),      .c(c1[g])
        );
    end

    // stage 2
    mac_row42 #(.W(OUT_W)) u_s2_42 (
        .x0(s1[0]), .x1(c1[0]), .x2(s1[1]), .x3(c1[1]),
        .s(s2a),    .c(c2a)
    );

    for (genvar i = 0; i < OUT_W; i++) begin : g_s2_32
        fa_t f;
        assign f = fa3(s1[2][i], c1[2][i], pp[OP_W-1][i]);
        assign s2b[i] = f.s;
        if (i == 0) begin : g_first
            assign c2b[0] = 1'b0;
        end else begin : g_chain
            assign c2b[i] = g_s2_32[i-1].f.c;
        end
        if (i == OUT_W-1) begin : g_top
            logic top_unused;
            assign top_unused = f.c;
        end
    end

    // stage 3
    mac_row42 #(.W(OUT_W)) u_s3_42 (
        .x0(s2a), .x1(c2a), .x2(s2b), .x3(c2b),
        .s(row_s), .c(row_c)
    );

endmodule

// File: rtl/mac_csla_cbl.sv
// Carry-select adder. Each block forms both of its candidate sums from shared
// propagate/generate terms, and the incoming block carry picks one.
// W must be a multiple of BLK.
module mac_csla_cbl #(
    parameter int W   = 32,
    parameter int BLK = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    localparam int NBLK = W / BLK;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        logic [BLK-1:0] p, g, s0, s1;
        logic [BLK:0]   c0, c1;
        logic           cin;
        logic           cout;

        always_comb begin
            c0[0] = 1'b0;
            c1[0] = 1'b1;
            for (int j = 0; j < BLK; j++) begin
                p[j]    = x[k*BLK+j] ^ y[k*BLK+j];
                g[j]    = x[k*BLK+j] & y[k*BLK+j];
                s0[j]   = p[j] ^ c0[j];
                s1[j]   = p[j] ^ c1[j];
                c0[j+1] = g[j] | (p[j] & c0[j]);
                c1[j+1] = g[j] | (p[j] & c1[j]);
            end
        end

        if (k == 0) begin : g_first
            assign cin = 1'b0;
        end else begin : g_chain
            assign cin = g_blk[k-1].cout;
        end

        assign sum[k*BLK +: BLK] = cin ? s1 : s0;
        assign cout              = cin ? c1[BLK] : c0[BLK];

        if (k == NBLK-1) begin : g_top
            logic carry_unused;
            assign carry_unused = cout;
        end
    end

endmodule

// File: rtl/mac_top.sv
module mac_top #(
    parameter int OP_W     = 16,
    parameter int ACC_W    = 32,
    parameter int CSLA_BLK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] acc_out
);
    import mac_pkg::*;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] row_s, row_c;
    logic [ACC_W-1:0] m_s, m_c;
    logic [ACC_W-1:0] acc_sum;
    acc_op_e          op_sel;

    mac_comp_tree #(.OP_W(OP_W), .OUT_W(ACC_W)) u_tree (
        .a(op_a), .b(op_b), .row_s(row_s), .row_c(row_c)
    );

    // merge the running total with the two product rows
    for (genvar i = 0; i < ACC_W; i++) begin : g_merge
        fa_t f;
        assign f      = fa3(acc_q[i], row_s[i], row_c[i]);
        assign m_s[i] = f.s;
        if (i == 0) begin : g_first
            assign m_c[0] = 1'b0;
        end else begin : g_chain
            assign m_c[i] = g_merge[i-1].f.c;
        end
        if (i == ACC_W-1) begin : g_top
            logic top_unused;
            assign top_unused = f.c;
        end
    end

    mac_csla_cbl #(.W(ACC_W), .BLK(CSLA_BLK)) u_add (
        .x(m_s), .y(m_c), .sum(acc_sum)
    );

    always_comb begin
        if (clr)     op_sel = ACC_ZERO;
        else if (en) op_sel = ACC_ADD;
        else         op_sel = ACC_HOLD;
    end

    always_comb begin
        acc_d = acc_q;
        unique case (op_sel)
            ACC_ZERO: acc_d = '0;
            ACC_ADD:  acc_d = acc_sum;
            ACC_HOLD: acc_d = acc_q;
            default:  acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_out = acc_q;

endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             en,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [ACC_W-1:0] acc_out,
    input logic [ACC_W-1:0] row_s,
    input logic [ACC_W-1:0] row_c
);
    localparam logic [ACC_W-1:0] ONES    = ACC_W'({OP_W{1'b1}});
    localparam logic [ACC_W-1:0] MAXPROD = ONES * ONES;

    logic [ACC_W-1:0] prod_ref;
    logic [ACC_W-1:0] rows_total;
    assign prod_ref   = ACC_W'(op_a) * ACC_W'(op_b);
    assign rows_total = row_s + row_c;

    a_r7_rows_sum: assert property (@(posedge clk) disable iff (!rst_n)
        rows_total == prod_ref);

    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> acc_out == $past(acc_out) + $past(prod_ref));

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc_out == '0);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc_out));

    a_r6_max_product: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && op_a == '1 && op_b == '1) |=> acc_out == $past(acc_out) + MAXPROD);

endmodule

bind mac_top mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .op_a(op_a), .op_b(op_b),
    .acc_out(acc_out), .row_s(row_s), .row_c(row_c)
);

// File: tb/mac_top_tb.sv
`timescale 1ns/1ps
module mac_top_tb;
    localparam int OP_W  = 16;
    localparam int ACC_W = 32;
    localparam int NTAP  = 21;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clr;
    logic             en;
    logic [OP_W-1:0]  op_a;
    logic [OP_W-1:0]  op_b;
    logic [ACC_W-1:0] acc_out;

    int checks   = 0;
    int failures = 0;
    logic [ACC_W-1:0] model = '0;   // behavioural expected total
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    mac_top #(.OP_W(OP_W), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .op_a(op_a), .op_b(op_b), .acc_out(acc_out)
    );

    task automatic check(input string tag, input logic [ACC_W-1:0] exp);
        checks++;
        if (acc_out !== exp) begin
            failures++;
            $display("FAIL %s: acc_out=%h expected=%h", tag, acc_out, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge,
    // then compare just after it.
    task automatic cyc(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input logic e, input logic c, input string tag);
        longint unsigned p;
        @(negedge clk);
        op_a = a; op_b = b; en = e; clr = c;
        @(posedge clk);
        p = longint'(a) * longint'(b);
        if (c)      model = '0;
        else if (e) model = ACC_W'(longint'(model) + p);
        #1;
        check(tag, model);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: acc_out=%h expected=run_complete", acc_out);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [OP_W-1:0] hq [$];
        logic [OP_W-1:0] xq [$];
        longint unsigned dot;
        rst_n = 1'b0; clr = 1'b0; en = 1'b0; op_a = '0; op_b = '0;
        #1;
        check("R1 reset value", '0);
        // R1: operands and enable are ignored while reset is held
        @(negedge clk); en = 1'b1; op_a = 16'h1234; op_b = 16'h0042;
        @(posedge clk); #1;
        check("R1 reset held with en", '0);
        @(negedge clk); rst_n = 1'b1; en = 1'b0;
        model = '0;

        // R2, R9: one enabled edge shows the sum immediately
        cyc(16'd3, 16'd5, 1'b1, 1'b0, "R9 single-edge update");
        cyc(16'h0100, 16'h0080, 1'b1, 1'b0, "R2 Q8 term");
        cyc(16'd0, 16'hFFFF, 1'b1, 1'b0, "R2 zero operand");
        // R5: idle edges with changing operands
        cyc(16'hAAAA, 16'h5555, 1'b0, 1'b0, "R5 hold");
        cyc(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R5 hold ones");
        // R4: clear wins over enable
        cyc(16'hFFFF, 16'h0001, 1'b1, 1'b1, "R4 clear with en");
        cyc(16'h0000, 16'h0000, 1'b0, 1'b1, "R4 clear idle");
        // R6 and R3: all-ones products wrap past 2^32
        cyc(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R6 all-ones product");
        cyc(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R3 second max term");
        cyc(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R3 wrap");
        checks++;
        if (acc_out !== 32'hFFFA0003) begin
            failures++;
            $display("FAIL R3: acc_out=%h expected=%h", acc_out, 32'hFFFA0003);
        end
        // R2: walking single-bit operands
        for (int i = 0; i < OP_W; i++)
            cyc(16'(1 << i), 16'(1 << (OP_W-1-i)), 1'b1, 1'b0, "R2 walking bit");

        // R8: 21-term dot product after a clear
        cyc(16'h0, 16'h0, 1'b0, 1'b1, "R8 clear before filter");
        dot = 0;
        for (int k = 0; k < NTAP; k++) begin
            hq.push_back(16'((k * 2731 + 97) & 16'hFFFF));
            xq.push_back(16'((k * 40503 + 12345) & 16'hFFFF));
        end
        hq[NTAP-1] = 16'hFFFF; xq[NTAP-1] = 16'hFFFF;
        for (int k = 0; k < NTAP; k++) begin
            dot += longint'(xq[k]) * longint'(hq[k]);
            cyc(xq[k], hq[k], 1'b1, 1'b0, "R8 filter term");
        end
        checks++;
        if (acc_out !== ACC_W'(dot)) begin
            failures++;
            $display("FAIL R8: acc_out=%h expected=%h", acc_out, ACC_W'(dot));
        end

        // R2 R4 R5: mixed traffic
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            cyc(16'($urandom), 16'($urandom), (r % 4) != 0, (r % 29) == 0, "R2 mixed run");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule